// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Controller

This block is a memory-mapped pulse-width modulator with four independent output channels. Each channel owns a 16-bit period count, a 16-bit duty count, a 6-bit prescaler, a polarity bit and an enable bit. Software sets these through a simple single-cycle register bus: address, write strobe, write data, and combinational read data. A channel's waveform starts with its active phase. The active phase lasts `(prescale+1)*duty` clocks, and one full period lasts `(prescale+1)*period` clocks.

A channel starts cleanly on every rising edge of its enable bit. While its enable bit is clear, it sits at the inactive level for its polarity. Period, duty and prescale values written to a running channel are held back until the current period ends, so no partial period is ever produced. The drive-type bits have no effect on the outputs. They are stored only so that software can read them back.

Top module: `pwm4_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero. Because the polarity bits are then 0 (inverted) and all channels are disabled, `pwm_out` is 4'hF.
- R2: Register map and readback:
  - The control register is at 0x00. Enable n is bit n, polarity n is bit 8+n, and drive type n is bit 15+n.
  - Period n is at 0x04+8n and duty n is at 0x08+8n. Each holds bits 15:0.
  - The prescale register is at 0x24 and holds bits 23:0.
  - Unused bits and unmapped addresses read zero.
- R3: With normal polarity, an enabled channel drives 1 for `(pre+1)*D` clocks and then 0 for the rest of a `(pre+1)*P` clock period, where D is the duty count and P the period count.
- R4: Channel n's prescale field sits at bits `(3-n)*6 +: 6` of the prescale register. Channel 0 uses bits 23:18 and channel 3 uses bits 5:0.
- R5: Polarity bit 1 gives an active-high output. Polarity bit 0 inverts the output.
- R6: While a channel's enable bit is 0, its counters are held at zero and its output is the inactive level: 0 for polarity 1, 1 for polarity 0.
- R7: A rising edge of an enable bit restarts the channel. Its first active clock is the second clock edge after the write that sets the bit.
- R8: A period count of 0 or 1 behaves as a period count of 2.
- R9: A duty count at or above the effective period count keeps the output active for the whole period. A duty count of 0 keeps it inactive.
- R10: Period, duty and prescale writes to a running channel take effect only at the next period boundary.
- R11: Writing one channel's settings neither restarts nor alters any other running channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 6 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pwm_out | output | 4 | PWM outputs, bit n is channel n |

## Verification
Faults in the internal state show up at the outputs in different ways:
- A wrong period counter or boundary compare makes a pulse train longer or shorter than `(pre+1)*P` within the first period.
- A latched shadow value that reloads early or late shows up as one malformed period around a mid-run write.
- A missed restart shows as a first active phase that is not in the expected clock after the enable write.
- A wrong prescale field position stretches the wrong channel.

Every waveform is compared clock by clock, so such faults are reported within one period of the stimulus.

// File: rtl/pwm4_pkg.sv
// Package: shared widths, register addresses and control bit positions
// for the four-channel PWM controller. Assumes a byte-addressed map.
package pwm4_pkg;
    localparam int NCH     = 4;
    localparam int CNT_W   = 16;
    localparam int PRE_W   = 6;
    localparam int ADDR_W  = 6;
    localparam int DATA_W  = 32;
    localparam int EN_LSB  = 0;
    localparam int POL_LSB = 8;
    localparam int TYP_LSB = 15;
    localparam int MIN_PER = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] A_PRE  = ADDR_W'(8'h24);

    // Address of channel n's period count
    function automatic logic [ADDR_W-1:0] a_per(input int n);
        return ADDR_W'(4 + 8 * n);
    endfunction

    // Address of channel n's duty count
    function automatic logic [ADDR_W-1:0] a_duty(input int n);
        return ADDR_W'(8 + 8 * n);
    endfunction
endpackage

// File: rtl/pwm4_regs.sv
// Register file: holds the control, period, duty and packed prescale
// settings. Writes land on the clock edge; reads are combinational.
// Assumes one access per cycle and a synchronous active-low reset.
module pwm4_regs
    import pwm4_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            addr,
    input  logic                         we,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata,
    output logic [NCH-1:0]               en,
    output logic [NCH-1:0]               pol,
    output logic [NCH-1:0][CNT_W-1:0]    per,
    output logic [NCH-1:0][CNT_W-1:0]    duty,
    output logic [NCH-1:0][PRE_W-1:0]    pre
);
    logic [NCH-1:0] typ;
    logic           unused_wdata;

    assign unused_wdata = ^wdata;

    // Register writes; every field clears on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= '0;
            pol  <= '0;
            typ  <= '0;
            per  <= '0;
            duty <= '0;
            pre  <= '0;
        end else if (we) begin
            for (int n = 0; n < NCH; n++) begin
                if (addr == A_CTRL) begin
                    en[n]  <= wdata[EN_LSB + n];
                    pol[n] <= wdata[POL_LSB + n];
                    typ[n] <= wdata[TYP_LSB + n];
                end
                if (addr == A_PRE)
                    pre[n] <= wdata[(NCH-1-n)*PRE_W +: PRE_W];
                if (addr == a_per(n))
                    per[n] <= wdata[CNT_W-1:0];
                if (addr == a_duty(n))
                    duty[n] <= wdata[CNT_W-1:0];
            end
        end
    end

    // Read mux; unused bits and unmapped addresses return zero
    always_comb begin
        rdata = '0;
        for (int n = 0; n < NCH; n++) begin
            if (addr == A_CTRL) begin
                rdata[EN_LSB + n]  = en[n];
                rdata[POL_LSB + n] = pol[n];
                rdata[TYP_LSB + n] = typ[n];
            end
            if (addr == A_PRE)
                rdata[(NCH-1-n)*PRE_W +: PRE_W] = pre[n];
            if (addr == a_per(n))
                rdata[CNT_W-1:0] = per[n];
            if (addr == a_duty(n))
                rdata[CNT_W-1:0] = duty[n];
        end
    end
endmodule

// File: rtl/pwm4_tick.sv
// Prescale tick generator: pulses tick once every (limit+1) clocks.
// A high clr holds the count at zero. Assumes limit is stable between
// clears or ticks.
module pwm4_tick #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] cnt;

    assign tick = (cnt == limit);

    // Divider count: wraps at limit, clears on reset or clr
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/pwm4_chan.sv
// One PWM channel: period and duty counting with shadow copies of the
// settings. Shadows load on an enable rising edge and at each period
// boundary. Assumes the settings come straight from the register file.
module pwm4_chan
    import pwm4_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             pol,
    input  logic [CNT_W-1:0] per,
    input  logic [CNT_W-1:0] duty,
    input  logic [PRE_W-1:0] pre,
    output logic             pwm
);
    logic             run_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] per_l;
    logic [CNT_W-1:0] duty_l;
    logic [PRE_W-1:0] pre_l;
    logic [CNT_W-1:0] per_eff;
    logic             running;
    logic             tick;
    logic             active;

    assign per_eff = (per < CNT_W'(MIN_PER)) ? CNT_W'(MIN_PER) : per;
    assign running = run_q && en;

    pwm4_tick #(.W(PRE_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!running),
        .limit (pre_l),
        .tick  (tick)
    );

    // Count state: restart on enable edge, reload shadows at boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            cnt    <= '0;
            per_l  <= CNT_W'(MIN_PER);
            duty_l <= '0;
            pre_l  <= '0;
        end else begin
            run_q <= en;
            if (!en) begin
                cnt <= '0;
            end else if (!run_q) begin
                cnt    <= '0;
                per_l  <= per_eff;
                duty_l <= duty;
                pre_l  <= pre;
            end else if (tick) begin
                if (cnt == per_l - CNT_W'(1)) begin
                    cnt    <= '0;
                    per_l  <= per_eff;
                    duty_l <= duty;
                    pre_l  <= pre;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end

    assign active = run_q && (cnt < duty_l);
    assign pwm    = pol ? active : !active;
endmodule

// File: rtl/pwm4_ctrl.sv
// Top level: the register file feeding four PWM channels, built by a
// generate loop. Assumes a single clock domain and synchronous reset.
module pwm4_ctrl
    import pwm4_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [3:0]        pwm_out
);
    logic [NCH-1:0]            en_v;
    logic [NCH-1:0]            pol_v;
    logic [NCH-1:0][CNT_W-1:0] per_v;
    logic [NCH-1:0][CNT_W-1:0] duty_v;
    logic [NCH-1:0][PRE_W-1:0] pre_v;

    pwm4_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .we    (bus_we),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .en    (en_v),
        .pol   (pol_v),
        .per   (per_v),
        .duty  (duty_v),
        .pre   (pre_v)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm4_chan u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en_v[g]),
            .pol   (pol_v[g]),
            .per   (per_v[g]),
            .duty  (duty_v[g]),
            .pre   (pre_v[g]),
            .pwm   (pwm_out[g])
        );
    end
endmodule

// File: rtl/pwm4_ctrl_chk.sv
// Checker: temporal properties of the PWM controller, bound to the top.
// Assumes it sees the top's register outputs by name.
module pwm4_ctrl_chk
    import pwm4_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_we,
    input  logic [5:0]                bus_addr,
    input  logic [31:0]               bus_wdata,
    input  logic [3:0]                pwm_out,
    input  logic [NCH-1:0]            en_v,
    input  logic [NCH-1:0]            pol_v,
    input  logic [NCH-1:0][CNT_W-1:0] duty_v,
    input  logic [NCH-1:0][PRE_W-1:0] pre_v
);
    logic unused_chk;
    assign unused_chk = ^bus_wdata;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (en_v == '0 && pol_v == '0 && pre_v == '0 && duty_v == '0));

    // R2
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CTRL) |=>
        (en_v == $past(bus_wdata[EN_LSB +: NCH]) && pol_v == $past(bus_wdata[POL_LSB +: NCH])));

    for (genvar g = 0; g < NCH; g++) begin : g_prop
        // R6
        idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_v[g] && !$past(en_v[g])) |-> (pwm_out[g] == !pol_v[g]));

        // R7
        restart_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(en_v[g]) && duty_v[g] != '0) |=> (pwm_out[g] == pol_v[g]));
    end
endmodule

bind pwm4_ctrl pwm4_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pwm_out   (pwm_out),
    .en_v      (en_v),
    .pol_v     (pol_v),
    .duty_v    (duty_v),
    .pre_v     (pre_v)
);

// File: tb/pwm4_ctrl_tb.sv
module pwm4_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int nchk = 0;
    int nerr = 0;
    logic [31:0] ctrl_sh = '0;
    logic [31:0] pre_sh = '0;

    typedef struct {
        logic [3:0] m;
        logic [3:0] e;
        string      r;
    } item_t;
    item_t sb[$];

    pwm4_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    always #5 clk = ~clk;

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    // Monitor: pops one expected item per falling edge and compares it
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            chk((pwm_out & it.m) === (it.e & it.m), it.r, 32'(pwm_out & it.m), 32'(it.e & it.m));
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string r);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1;
        chk(bus_rdata === exp, r, bus_rdata, exp);
    endtask

    // Configure and enable one channel; returns on the load edge
    task automatic start(input int ch, input int pre, input int p, input int d, input bit pol);
        ctrl_sh[ch] = 1'b0;
        wr(6'h00, ctrl_sh);
        wr(6'(4 + 8 * ch), 32'(p));
        wr(6'(8 + 8 * ch), 32'(d));
        pre_sh[(3 - ch) * 6 +: 6] = 6'(pre);
        wr(6'h24, pre_sh);
        ctrl_sh[ch] = 1'b1;
        ctrl_sh[8 + ch] = pol;
        wr(6'h00, ctrl_sh);
        @(posedge clk);
    endtask

    task automatic push1(input int ch, input bit v, input logic [3:0] om, input logic [3:0] ov, input string r);
        item_t it;
        it.m = om | (4'b1 << ch);
        it.e = (ov & om) | (4'(v) << ch);
        it.r = r;
        sb.push_back(it);
    endtask

    // Driver: pushes the expected waveform computed from the requirements
    task automatic expect_wave(input int ch, input int pre, input int p, input int d, input bit pol,
                               input int n, input logic [3:0] om, input logic [3:0] ov, input string r);
        int pe, lp, lh;
        pe = (p < 2) ? 2 : p;
        lp = (pre + 1) * pe;
        lh = (pre + 1) * ((d >= pe) ? pe : d);
        for (int k = 0; k < n; k++) begin
            bit act;
            act = (k % lp) < lh;
            push1(ch, pol ? act : !act, om, ov, r);
        end
    endtask

    task automatic drain();
        while (sb.size() > 0) @(posedge clk);
        @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(pwm_out === 4'hF, "R1 outputs", 32'(pwm_out), 32'hF);
        rd(6'h00, 32'h0, "R1 ctrl");
        rd(6'h24, 32'h0, "R1 prescale");
        rd(6'h1C, 32'h0, "R1 period3");

        // R2 readback and masking
        wr(6'h00, 32'hFFFF_FFFF);
        rd(6'h00, 32'h0007_8F0F, "R2 ctrl mask");
        wr(6'h00, 32'h0);
        wr(6'h04, 32'hABCD_1234);
        rd(6'h04, 32'h0000_1234, "R2 period0");
        wr(6'h20, 32'h0000_5678);
        rd(6'h20, 32'h0000_5678, "R2 duty3");
        wr(6'h24, 32'hFFFF_FFFF);
        rd(6'h24, 32'h00FF_FFFF, "R2 prescale");
        wr(6'h3C, 32'hFFFF_FFFF);
        rd(6'h3C, 32'h0, "R2 unmapped");
        wr(6'h24, 32'h0);

        // R3 basic waveform, normal polarity
        start(0, 0, 5, 2, 1'b1);
        expect_wave(0, 0, 5, 2, 1'b1, 20, 4'h0, 4'h0, "R3 wave");
        drain();

        // R4 prescale field placement, channel 0 and channel 3
        start(0, 2, 3, 1, 1'b1);
        expect_wave(0, 2, 3, 1, 1'b1, 18, 4'h0, 4'h0, "R4 ch0 prescale");
        drain();
        start(3, 1, 2, 1, 1'b1);
        expect_wave(3, 1, 2, 1, 1'b1, 12, 4'h0, 4'h0, "R4 ch3 prescale");
        drain();

        // R5 inverted polarity
        start(1, 1, 4, 1, 1'b0);
        expect_wave(1, 1, 4, 1, 1'b0, 16, 4'h0, 4'h0, "R5 inverted");
        drain();

        // R8 period clamp
        start(2, 0, 1, 1, 1'b1);
        expect_wave(2, 0, 1, 1, 1'b1, 8, 4'h0, 4'h0, "R8 period1");
        drain();
        start(2, 0, 0, 1, 1'b1);
        expect_wave(2, 0, 0, 1, 1'b1, 8, 4'h0, 4'h0, "R8 period0");
        drain();

        // R9 duty extremes
        start(2, 0, 3, 0, 1'b1);
        expect_wave(2, 0, 3, 0, 1'b1, 9, 4'h0, 4'h0, "R9 duty zero");
        drain();
        start(2, 0, 3, 5, 1'b1);
        expect_wave(2, 0, 3, 5, 1'b1, 9, 4'h0, 4'h0, "R9 duty over period");
        drain();

        // R11 channel 2 stays high while channel 1 is reprogrammed
        start(1, 0, 4, 3, 1'b1);
        expect_wave(1, 0, 4, 3, 1'b1, 12, 4'b0100, 4'b0100, "R11 independence");
        drain();

        // R10 mid-run update waits for the boundary
        start(0, 0, 4, 2, 1'b1);
        expect_wave(0, 0, 4, 2, 1'b1, 4, 4'h0, 4'h0, "R10 old period");
        expect_wave(0, 0, 6, 3, 1'b1, 12, 4'h0, 4'h0, "R10 new period");
        wr(6'h04, 32'd6);
        wr(6'h08, 32'd3);
        drain();

        // R6 disabled output idles at inactive level
        ctrl_sh[0] = 1'b0;
        wr(6'h00, ctrl_sh);
        @(posedge clk);
        for (int k = 0; k < 5; k++) push1(0, 1'b0, 4'h0, 4'h0, "R6 disabled idle");
        drain();

        // R7 re-enable restarts from the active phase
        ctrl_sh[0] = 1'b1;
        wr(6'h00, ctrl_sh);
        @(posedge clk);
        expect_wave(0, 0, 6, 3, 1'b1, 12, 4'h0, 4'h0, "R7 restart");
        drain();

        finish_run();
    end
endmodule